// File: doc/BRIEF.md
# Iterative Shuffle Network Engine

The engine holds a set of sixteen operand words and runs a fixed number of iterations over them. In each iteration the words are taken in adjacent pairs, (0,1), (2,3) and so on up to (14,15), and each pair goes through one shared operator. The operator returns the pair's sum and difference. The sixteen results are then rearranged by a perfect shuffle and become the operands of the next iteration.

A single two-stage pipelined operator handles all eight pair operations of an iteration, one per clock. The words live in two register banks that trade roles every iteration. Reads come from the current source bank, and writes go to the other bank at their shuffled positions. Before the next iteration reads anything, the sequencer waits until the last operation of the current one has been written back.

Software loads the words while the engine is idle and pulses `start`. It then waits for the one-cycle `done` pulse and reads the results through a combinational read port. One iteration takes 10 clocks. At the default of 256 iterations a run therefore takes 2560 clocks, so a 50 MHz clock finishes it within a 51.2 µs operand period.

Top module: `shuffle_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are both 0.
- R2: While the engine is idle, `ld_en` high on a clock edge stores `ld_data` into word `ld_addr`. From the following cycle, `rd_data` shows that word whenever `rd_addr` selects it.
- R3: Every iteration takes word pairs (2k, 2k+1) for k = 0..7 and forms a = word[2k] and b = word[2k+1]. The sum a+b is the result for index 2k and the difference a−b is the result for index 2k+1, both taken modulo 2^W.
- R4: A result for index i (4 bits) is stored at index {i[2:0], i[3]}, which is i rotated left by one bit. These stored words are the operands of the next iteration.
- R5: A run performs exactly ITERATIONS iterations. After `done`, word j read on `rd_data` equals the result of applying R3 and R4 ITERATIONS times to the loaded set.
- R6: Let S be the cycle in which `start` is sampled high while the engine is idle. `busy` is high from cycle S+1 onward. `done` is high for exactly one cycle, S+10·ITERATIONS+1, and `busy` is low in that cycle.
- R7: A `start` pulse while `busy` is high is ignored. The run in progress keeps its `done` timing and its results.
- R8: `ld_en` while `busy` is high is ignored. No operand or result word changes because of it.
- R9: The operator accepts one pair per clock and eight pairs per iteration. No pair of a new iteration is issued while a result of the previous iteration is still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one operand word (idle only) |
| ld_addr | input | 4 | Index of the word being loaded |
| ld_data | input | W | Operand word being loaded |
| start | input | 1 | Begin a run (idle only) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the run has finished |
| rd_addr | input | 4 | Index of the word to read |
| rd_data | output | W | Current word at `rd_addr` |

## Verification
The bench builds the engine with W = 8 and ITERATIONS = 3. With an 8-bit word, sums and differences wrap on almost every operation, so the modulo behaviour gets exercised heavily. Three iterations is an odd count, so the results end up in the opposite bank from the loaded operands, and every pair position passes through the shuffle more than once. The short run also keeps the exact `done` cycle easy to count. That makes it easy to check that a mid-run `start` or `ld_en` leaves both the timing and the results unchanged.

// File: rtl/shuffle_engine_pkg.sv
package shuffle_engine_pkg;

    localparam int ADDR_W    = 4;
    localparam int NUM_WORDS = 1 << ADDR_W;
    localparam int PAIR_W    = ADDR_W - 1;
    localparam int NUM_PAIRS = NUM_WORDS / 2;
    localparam int PIPE_DEPTH = 2;

    typedef logic [ADDR_W-1:0] word_idx_t;
    typedef logic [PAIR_W-1:0] pair_idx_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ISSUE,
        SEQ_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic      valid;
        pair_idx_t pair;
    } issue_t;

    function automatic word_idx_t lane_index(input pair_idx_t p, input logic odd);
        return {p, odd};
    endfunction

    function automatic word_idx_t shuffle_dest(input word_idx_t src);
        return {src[ADDR_W-2:0], src[ADDR_W-1]};
    endfunction

endpackage

// File: rtl/shuffle_engine_op.sv
module shuffle_engine_op
    import shuffle_engine_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  issue_t       iss,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         s1_valid,
    output issue_t       wr,
    output logic [W-1:0] wr_sum,
    output logic [W-1:0] wr_diff
);

    issue_t       s1;
    logic [W-1:0] s1_a;
    logic [W-1:0] s1_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            wr <= '0;
        end else begin
            s1 <= iss;
            wr <= s1;
        end
    end

    always_ff @(posedge clk) begin
        s1_a    <= opa;
        s1_b    <= opb;
        wr_sum  <= s1_a + s1_b;
        wr_diff <= s1_a - s1_b;
    end

    assign s1_valid = s1.valid;

    // R9: an issued pair occupies stage one on the next cycle
    p_stage_advance_r9: assert property (@(posedge clk) disable iff (rst)
        iss.valid |=> s1.valid);

    // R3: stage one always hands its pair to the write stage
    p_result_follows_r3: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> (wr.valid && wr.pair == $past(s1.pair)));

endmodule

// File: rtl/shuffle_engine_bank.sv
module shuffle_engine_bank
    import shuffle_engine_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         load_en,
    input  word_idx_t    load_addr,
    input  logic [W-1:0] load_data,
    input  pair_idx_t    rd_pair,
    output logic [W-1:0] opa,
    output logic [W-1:0] opb,
    input  issue_t       wr,
    input  logic [W-1:0] wr_sum,
    input  logic [W-1:0] wr_diff,
    input  word_idx_t    ext_addr,
    output logic [W-1:0] ext_data
);

    logic [W-1:0] mem [2][NUM_WORDS];

    always_ff @(posedge clk) begin
        if (load_en)
            mem[sel][load_addr] <= load_data;
        if (wr.valid) begin
            mem[!sel][shuffle_dest(lane_index(wr.pair, 1'b0))] <= wr_sum;
            mem[!sel][shuffle_dest(lane_index(wr.pair, 1'b1))] <= wr_diff;
        end
    end

    assign opa      = mem[sel][lane_index(rd_pair, 1'b0)];
    assign opb      = mem[sel][lane_index(rd_pair, 1'b1)];
    assign ext_data = mem[sel][ext_addr];

    // R8: a host load never coincides with a result write
    p_no_write_clash_r8: assert property (@(posedge clk) disable iff (rst)
        load_en |-> !wr.valid);

endmodule

// File: rtl/shuffle_engine_seq.sv
module shuffle_engine_seq
    import shuffle_engine_pkg::*;
#(
    parameter int ITERATIONS = 256
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   pipe_s1_valid,
    input  logic   pipe_wr_valid,
    output issue_t iss,
    output logic   sel,
    output logic   busy,
    output logic   done
);

    localparam int        ITER_W    = $clog2(ITERATIONS) + 1;
    localparam pair_idx_t LAST_PAIR = pair_idx_t'(NUM_PAIRS - 1);
    localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(ITERATIONS - 1);

    seq_state_e        state;
    pair_idx_t         pair;
    logic [ITER_W-1:0] iter;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            pair  <= '0;
            iter  <= '0;
            sel   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_ISSUE;
                        pair  <= '0;
                        iter  <= '0;
                    end
                end
                SEQ_ISSUE: begin
                    pair <= pair + 1'b1;
                    if (pair == LAST_PAIR)
                        state <= SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    // the last write retires on this edge, so flipping now is safe
                    if (!pipe_s1_valid) begin
                        sel  <= !sel;
                        pair <= '0;
                        if (iter == LAST_ITER) begin
                            state <= SEQ_IDLE;
                            done  <= 1'b1;
                        end else begin
                            iter  <= iter + 1'b1;
                            state <= SEQ_ISSUE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        iss.valid = (state == SEQ_ISSUE);
        iss.pair  = pair;
    end

    assign busy = (state != SEQ_IDLE);

    // R9: the first pair of an iteration never meets in-flight results
    p_issue_clean_r9: assert property (@(posedge clk) disable iff (rst)
        (iss.valid && pair == '0) |-> (!pipe_s1_valid && !pipe_wr_valid));

    // R6: done lasts a single cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the engine is idle whenever done is shown
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: start during a run keeps the sequencer busy rather than restarting
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state == SEQ_ISSUE && pair != LAST_PAIR) |=> (state == SEQ_ISSUE && pair == $past(pair) + 1'b1));

endmodule

// File: rtl/shuffle_engine.sv
module shuffle_engine
    import shuffle_engine_pkg::*;
#(
    parameter int W          = 16,
    parameter int ITERATIONS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [W-1:0]      ld_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data
);

    issue_t       iss;
    issue_t       wr;
    logic         sel;
    logic         s1_valid;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] wr_sum;
    logic [W-1:0] wr_diff;
    logic         load_en;

    assign load_en = ld_en && !busy;

    shuffle_engine_seq #(
        .ITERATIONS(ITERATIONS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .pipe_s1_valid(s1_valid),
        .pipe_wr_valid(wr.valid),
        .iss          (iss),
        .sel          (sel),
        .busy         (busy),
        .done         (done)
    );

    shuffle_engine_bank #(
        .W(W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .load_en  (load_en),
        .load_addr(ld_addr),
        .load_data(ld_data),
        .rd_pair  (iss.pair),
        .opa      (opa),
        .opb      (opb),
        .wr       (wr),
        .wr_sum   (wr_sum),
        .wr_diff  (wr_diff),
        .ext_addr (rd_addr),
        .ext_data (rd_data)
    );

    shuffle_engine_op #(
        .W(W)
    ) u_op (
        .clk     (clk),
        .rst     (rst),
        .iss     (iss),
        .opa     (opa),
        .opb     (opb),
        .s1_valid(s1_valid),
        .wr      (wr),
        .wr_sum  (wr_sum),
        .wr_diff (wr_diff)
    );

endmodule

// File: tb/shuffle_engine_test.sv
module shuffle_engine_test;

    localparam int TW = 8;
    localparam int TI = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [3:0]    ld_addr = '0;
    logic [TW-1:0] ld_data = '0;
    logic          start = 1'b0;
    logic          busy;
    logic          done;
    logic [3:0]    rd_addr = '0;
    logic [TW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [TW-1:0] exp_q[$];

    always #10 clk = ~clk;

    shuffle_engine #(.W(TW), .ITERATIONS(TI)) uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .start(start), .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_set(input logic [TW-1:0] v [16]);
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #1;
            ld_en = 1'b1; ld_addr = 4'(i); ld_data = v[i];
        end
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    // driver side: reference model from R3, R4 and R5, pushed to the scoreboard
    task automatic push_expected(input logic [TW-1:0] v [16]);
        logic [TW-1:0] cur [16];
        logic [TW-1:0] nxt [16];
        cur = v;
        for (int it = 0; it < TI; it++) begin
            for (int k = 0; k < 8; k++) begin
                int s, d;
                s = ((2*k) * 2) % 16 + ((2*k) >= 8 ? 1 : 0);
                d = ((2*k+1) * 2) % 16 + ((2*k+1) >= 8 ? 1 : 0);
                nxt[s] = TW'(cur[2*k] + cur[2*k+1]);
                nxt[d] = TW'(cur[2*k] - cur[2*k+1]);
            end
            cur = nxt;
        end
        for (int j = 0; j < 16; j++) exp_q.push_back(cur[j]);
    endtask

    // monitor side: read results out and compare against the queue
    task automatic drain_results(input string tag);
        for (int j = 0; j < 16; j++) begin
            logic [TW-1:0] e;
            rd_addr = 4'(j);
            #2;
            e = exp_q.pop_front();
            check({tag, " R5 word"}, int'(rd_data), int'(e));
        end
    endtask

    task automatic run_and_time(input bit inject);
        int cyc;
        int done_at;
        int pulses;
        @(posedge clk); #1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        done_at = -1;
        pulses = 0;
        cyc = 0;
        repeat (10*TI + 6) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) check("R6 busy after start", int'(busy), 1);
            if (done) begin
                pulses++;
                if (done_at < 0) begin
                    done_at = cyc;
                    check("R6 busy low with done", int'(busy), 0);
                end
            end
            if (inject && cyc == 4) begin
                start = 1'b1; ld_en = 1'b1; ld_addr = 4'd0; ld_data = 8'h5A;
            end
            if (inject && cyc == 5) begin
                start = 1'b0; ld_en = 1'b0;
            end
        end
        check(inject ? "R7 done cycle" : "R6 done cycle", done_at, 10*TI + 1);
        check("R6 single done pulse", pulses, 1);
        check("R6 idle after run", int'(busy), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [TW-1:0] pa [16];
        logic [TW-1:0] pb [16];
        logic [TW-1:0] pc [16];
        for (int i = 0; i < 16; i++) begin
            pa[i] = TW'(i * 7 + 3);
            pb[i] = TW'(8'hF0 ^ (i * 29));
            pc[i] = (i == 5) ? 8'd1 : 8'd0;
        end

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);

        // R2: load and read back before any run
        load_set(pa);
        for (int i = 0; i < 16; i++) begin
            rd_addr = 4'(i);
            #2;
            check("R2 readback", int'(rd_data), int'(pa[i]));
        end

        // R3 R4 R5 R6: plain run
        push_expected(pa);
        run_and_time(1'b0);
        drain_results("R3 R4 set A");

        // R7 R8: start and load during the run are ignored
        load_set(pb);
        push_expected(pb);
        run_and_time(1'b1);
        drain_results("R8 set B");

        // single one-hot operand traces the shuffle path (R4)
        load_set(pc);
        push_expected(pc);
        run_and_time(1'b0);
        drain_results("R4 one-hot");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule